// File: doc/BRIEF.md
# FIFO Threshold and Drain Controller

This block sits between a serial bus engine and a host or DMA port. It holds a receive FIFO, filled by the bus engine and emptied by the host, and a transmit FIFO, filled by the host and emptied by the bus engine. Each direction has a threshold programmed as a 6-bit field plus one. A one-cycle service request is raised whenever a full threshold's worth of data can be moved. The next request waits until the host has done that many accesses.

A transfer's length need not be a multiple of the threshold. When the last part is smaller than a threshold, the block raises a drain status bit instead of a service request. The host then reads the receive occupancy, or the transmit bytes still owed, and does exactly that many accesses. Host accesses that go beyond the data available set an access-error bit. All status bits are sticky and cleared by writing one. A single interrupt line is the OR of the enabled status bits.

Top module: `fdc_top`

## Requirements
- R1: The active threshold of each direction equals its 6-bit field plus one. A field of 0 gives a threshold of one byte, and a field of 63 gives 64 bytes.
- R2: `rx_req` is high for exactly one cycle when the receive occupancy is at least the RX threshold and no earlier receive request is still outstanding. A request stays outstanding until the host has popped threshold-many bytes. Each request sets status bit 3.
- R3: During a master-transmit transfer, `tx_req` is high for one cycle when all three of these hold: the TX free space is at least the TX threshold, `tx_left` is at least the TX threshold, and no earlier transmit request is outstanding. Each request sets status bit 4.
- R4: Once a receive-mode transfer has ended (`xfer_end` with `mode_tx` low), no receive request is outstanding, and the occupancy lies strictly between 0 and the RX threshold, status bit 13 (receive drain) is set. The bit is set two clock edges after `xfer_end` when these conditions already hold. It is never set when the FIFO is empty at the end of a transfer.
- R5: In a master-transmit transfer, status bit 14 (transmit drain) is set when no transmit request is outstanding and `tx_left` is non-zero but below the TX threshold. At that point `tx_left` equals `xfer_len` modulo the threshold when the host wrote in whole bursts. A transfer shorter than the threshold raises no `tx_req`.
- R6: Each drain bit is raised at most once per transfer, and a new `xfer_start` re-arms it.
- R7: `rx_level` is the number of bytes held in the receive FIFO. `tx_left` is loaded from `xfer_len` by `xfer_start` and drops by one on each accepted host write. Both reset to 0.
- R8: Status bit 7 (access error) is set when the host pops an empty receive FIFO. It is also set when the host writes while the transmit FIFO is full or `tx_left` is 0. The rejected access changes neither `rx_level` nor `tx_left`.
- R9: Status bits stay set until written with a one on `stat_clr`. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: The enable bits reset to 0 and are changed by `irq_en_set` and `irq_en_clr`. `irq` is high exactly when some status bit and its enable are both set.
- R11: Both FIFOs return bytes in arrival order, with the oldest byte on the data output. A bus push into a full receive FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_thr_field | input | 6 | RX threshold minus one |
| tx_thr_field | input | 6 | TX threshold minus one |
| xfer_len | input | 16 | Byte count of the transfer |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_end | input | 1 | End-of-transfer strobe from the bus engine |
| mode_tx | input | 1 | 1: master transmit, 0: receive |
| bus_rx_push | input | 1 | Bus engine writes a received byte |
| bus_rx_data | input | 8 | Received byte |
| host_rx_pop | input | 1 | Host reads a byte |
| host_rx_data | output | 8 | Oldest received byte |
| host_tx_push | input | 1 | Host writes a byte to send |
| host_tx_data | input | 8 | Byte to send |
| bus_tx_pop | input | 1 | Bus engine takes a byte |
| bus_tx_data | output | 8 | Oldest byte to send |
| rx_level | output | 7 | Receive FIFO occupancy |
| tx_left | output | 16 | Bytes the host still owes |
| rx_req | output | 1 | Receive service request pulse |
| tx_req | output | 1 | Transmit service request pulse |
| irq_en_set | input | 16 | Write-one-to-set enables |
| irq_en_clr | input | 16 | Write-one-to-clear enables |
| stat_clr | input | 16 | Write-one-to-clear status |
| irq_en | output | 16 | Enable bits |
| irq_raw | output | 16 | Sticky status bits |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle, the assertions check several properties. Service requests never last longer than one cycle. The FIFO occupancy never exceeds the depth, and a push into a full FIFO leaves it unchanged. A rising receive-drain bit is preceded by a legal occupancy. Bad host accesses always set the error bit, and status bits only drop when cleared. Only the directed scenarios can show the rest: the arithmetic of thresholds and remainders against `xfer_len`, data order through both FIFOs, the once-per-transfer drain with re-arming, and interrupt gating through the enable bank.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
   localparam int STAT_W       = 16;
   localparam int BIT_RX_REQ   = 3;
   localparam int BIT_TX_REQ   = 4;
   localparam int BIT_ACC_ERR  = 7;
   localparam int BIT_RX_DRAIN = 13;
   localparam int BIT_TX_DRAIN = 14;

   localparam logic [STAT_W-1:0] STAT_IMPL =
      (STAT_W'(1) << BIT_RX_REQ)   | (STAT_W'(1) << BIT_TX_REQ) |
      (STAT_W'(1) << BIT_ACC_ERR)  | (STAT_W'(1) << BIT_RX_DRAIN) |
      (STAT_W'(1) << BIT_TX_DRAIN);

   typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} fdc_dir_e;
endpackage

// File: rtl/fdc_fifo.sv
module fdc_fifo #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int LW   = $clog2(DEPTH + 1),
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fdc_fifo: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst_n) p_no_overflow_r11: assert (level <= LW'(DEPTH));
   end

   p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (level == $past(level)));
endmodule

// File: rtl/fdc_thresh.sv
module fdc_thresh #(
   parameter int TW = 7,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   input  logic [TW-1:0] thr,
   input  logic [AW-1:0] avail_a,
   input  logic [AW-1:0] avail_b,
   input  logic          served,
   output logic          req,
   output logic          idle
);
   logic [TW-1:0] owed;
   logic [AW-1:0] thr_x;

   generate
      if (AW < TW) begin : g_bad_width
         $error("fdc_thresh: AW must not be narrower than TW");
      end
   endgenerate

   assign thr_x = AW'(thr);
   assign idle  = (owed == '0);
   assign req   = en & idle & (avail_a >= thr_x) & (avail_b >= thr_x);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    owed <= '0;
      else if (req)                  owed <= thr - TW'(served);
      else if (clr)                  owed <= '0;
      else if (served && owed != '0) owed <= owed - TW'(1);
   end

   // Serves R2 and R3: a request never lasts two cycles.
   p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);
endmodule

// File: rtl/fdc_status.sv
module fdc_status
   import fdc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set,
   input  logic [STAT_W-1:0] clr,
   input  logic [STAT_W-1:0] en_set,
   input  logic [STAT_W-1:0] en_clr,
   output logic [STAT_W-1:0] raw,
   output logic [STAT_W-1:0] en,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw <= '0;
         en  <= '0;
      end else begin
         raw <= ((raw & ~clr) | set) & STAT_IMPL;
         en  <= ((en & ~en_clr) | en_set) & STAT_IMPL;
      end
   end

   assign irq = |(raw & en);

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw & $past(raw & ~clr)) == $past(raw & ~clr)));

   p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en != '0));
endmodule

// File: rtl/fdc_top.sv
module fdc_top
   import fdc_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DW     = 8,
   parameter int THR_W  = 6,
   parameter int CNT_W  = 16,
   localparam int LW    = $clog2(DEPTH + 1),
   localparam int TW    = THR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [THR_W-1:0]  rx_thr_field,
   input  logic [THR_W-1:0]  tx_thr_field,
   input  logic [CNT_W-1:0]  xfer_len,
   input  logic              xfer_start,
   input  logic              xfer_end,
   input  logic              mode_tx,
   input  logic              bus_rx_push,
   input  logic [DW-1:0]     bus_rx_data,
   input  logic              host_rx_pop,
   output logic [DW-1:0]     host_rx_data,
   input  logic              host_tx_push,
   input  logic [DW-1:0]     host_tx_data,
   input  logic              bus_tx_pop,
   output logic [DW-1:0]     bus_tx_data,
   output logic [LW-1:0]     rx_level,
   output logic [CNT_W-1:0]  tx_left,
   output logic              rx_req,
   output logic              tx_req,
   input  logic [STAT_W-1:0] irq_en_set,
   input  logic [STAT_W-1:0] irq_en_clr,
   input  logic [STAT_W-1:0] stat_clr,
   output logic [STAT_W-1:0] irq_en,
   output logic [STAT_W-1:0] irq_raw,
   output logic              irq
);
   generate
      if (DEPTH < (1 << THR_W)) begin : g_bad_depth
         $error("fdc_top: DEPTH must hold the largest threshold");
      end
      if (CNT_W <= LW) begin : g_bad_cnt
         $error("fdc_top: CNT_W must exceed the level width");
      end
   endgenerate

   logic [TW-1:0]     rx_thr, tx_thr;
   logic [CNT_W-1:0]  rx_thr_x, tx_thr_x, rx_level_x, tx_free_x;
   logic [LW-1:0]     tx_level;
   logic              rx_full, rx_empty, tx_full, tx_empty;
   logic              rx_pop_ok, tx_push_ok, acc_err;
   logic              rx_idle, tx_idle;
   logic              tx_active, rx_end_seen, rx_drained, tx_drained;
   logic              rx_drain_set, tx_drain_set;
   logic [STAT_W-1:0] stat_set;

   assign rx_thr     = TW'(rx_thr_field) + TW'(1);
   assign tx_thr     = TW'(tx_thr_field) + TW'(1);
   assign rx_thr_x   = CNT_W'(rx_thr);
   assign tx_thr_x   = CNT_W'(tx_thr);
   assign rx_level_x = CNT_W'(rx_level);
   assign tx_free_x  = CNT_W'(LW'(DEPTH) - tx_level);

   assign rx_pop_ok  = host_rx_pop & ~rx_empty;
   assign tx_push_ok = host_tx_push & ~tx_full & (tx_left != '0);
   assign acc_err    = (host_rx_pop & rx_empty) |
                       (host_tx_push & (tx_full | (tx_left == '0)));

   fdc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(bus_rx_push), .wdata(bus_rx_data),
      .pop(rx_pop_ok), .rdata(host_rx_data),
      .level(rx_level), .full(rx_full), .empty(rx_empty)
   );

   fdc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push_ok), .wdata(host_tx_data),
      .pop(bus_tx_pop), .rdata(bus_tx_data),
      .level(tx_level), .full(tx_full), .empty(tx_empty)
   );

   fdc_thresh #(.TW(TW), .AW(CNT_W)) u_rx_thresh (
      .clk(clk), .rst_n(rst_n),
      .en(1'b1), .clr(1'b0), .thr(rx_thr),
      .avail_a(rx_level_x), .avail_b({CNT_W{1'b1}}),
      .served(rx_pop_ok), .req(rx_req), .idle(rx_idle)
   );

   fdc_thresh #(.TW(TW), .AW(CNT_W)) u_tx_thresh (
      .clk(clk), .rst_n(rst_n),
      .en(tx_active), .clr(xfer_start), .thr(tx_thr),
      .avail_a(tx_free_x), .avail_b(tx_left),
      .served(tx_push_ok), .req(tx_req), .idle(tx_idle)
   );

   assign rx_drain_set = rx_end_seen & rx_idle & ~rx_drained &
                         (rx_level_x != '0) & (rx_level_x < rx_thr_x);
   assign tx_drain_set = tx_active & tx_idle & ~tx_drained &
                         (tx_left != '0) & (tx_left < tx_thr_x);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_active   <= 1'b0;
         rx_end_seen <= 1'b0;
         rx_drained  <= 1'b0;
         tx_drained  <= 1'b0;
         tx_left     <= '0;
      end else if (xfer_start) begin
         tx_active   <= (mode_tx == DIR_TX);
         rx_end_seen <= 1'b0;
         rx_drained  <= 1'b0;
         tx_drained  <= 1'b0;
         tx_left     <= xfer_len;
      end else begin
         if (xfer_end) begin
            tx_active <= 1'b0;
            if (mode_tx == DIR_RX) rx_end_seen <= 1'b1;
         end
         if (rx_drain_set) rx_drained <= 1'b1;
         if (tx_drain_set) tx_drained <= 1'b1;
         if (tx_push_ok)   tx_left    <= tx_left - CNT_W'(1);
      end
   end

   always_comb begin
      stat_set               = '0;
      stat_set[BIT_RX_REQ]   = rx_req;
      stat_set[BIT_TX_REQ]   = tx_req;
      stat_set[BIT_ACC_ERR]  = acc_err;
      stat_set[BIT_RX_DRAIN] = rx_drain_set;
      stat_set[BIT_TX_DRAIN] = tx_drain_set;
   end

   fdc_status u_status (
      .clk(clk), .rst_n(rst_n),
      .set(stat_set), .clr(stat_clr),
      .en_set(irq_en_set), .en_clr(irq_en_clr),
      .raw(irq_raw), .en(irq_en), .irq(irq)
   );

   p_rx_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_raw[BIT_RX_DRAIN]) |->
         ($past(rx_level) != '0 && CNT_W'($past(rx_level)) < CNT_W'($past(rx_thr))));

   p_acc_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rx_pop && rx_level == '0) |=> irq_raw[BIT_ACC_ERR]);

   p_tx_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_tx_push && !tx_full && tx_left != '0 && !xfer_start)
         |=> (tx_left == $past(tx_left) - CNT_W'(1)));

   p_tx_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_raw[BIT_TX_DRAIN]) |-> ($past(tx_left) != '0));
endmodule

// File: tb/test_fdc_top.sv
module test_fdc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  rx_thr_field = '0, tx_thr_field = '0;
   logic [15:0] xfer_len = '0;
   logic        xfer_start = 0, xfer_end = 0, mode_tx = 0;
   logic        bus_rx_push = 0, host_rx_pop = 0, host_tx_push = 0, bus_tx_pop = 0;
   logic [7:0]  bus_rx_data = '0, host_tx_data = '0;
   logic [7:0]  host_rx_data, bus_tx_data;
   logic [6:0]  rx_level;
   logic [15:0] tx_left;
   logic        rx_req, tx_req, irq;
   logic [15:0] irq_en_set = '0, irq_en_clr = '0, stat_clr = '0;
   logic [15:0] irq_en, irq_raw;
   int          vectors = 0, fails = 0;

   always #10 clk = ~clk;

   fdc_top i_fdc_top (
      .clk(clk), .rst_n(rst_n),
      .rx_thr_field(rx_thr_field), .tx_thr_field(tx_thr_field),
      .xfer_len(xfer_len), .xfer_start(xfer_start), .xfer_end(xfer_end),
      .mode_tx(mode_tx),
      .bus_rx_push(bus_rx_push), .bus_rx_data(bus_rx_data),
      .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
      .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
      .bus_tx_pop(bus_tx_pop), .bus_tx_data(bus_tx_data),
      .rx_level(rx_level), .tx_left(tx_left),
      .rx_req(rx_req), .tx_req(tx_req),
      .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr), .stat_clr(stat_clr),
      .irq_en(irq_en), .irq_raw(irq_raw), .irq(irq)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      stat_clr = '1; step(); stat_clr = '0;
   endtask

   task automatic rx_push(input logic [7:0] d);
      bus_rx_push = 1; bus_rx_data = d; step(); bus_rx_push = 0;
   endtask

   task automatic rx_pop_chk(input string req, input logic [7:0] exp);
      chk(req, host_rx_data, exp);
      host_rx_pop = 1; step(); host_rx_pop = 0;
   endtask

   task automatic tx_write(input logic [7:0] d);
      host_tx_push = 1; host_tx_data = d; step(); host_tx_push = 0;
   endtask

   task automatic start_xfer(input logic tx, input logic [15:0] len);
      mode_tx = tx; xfer_len = len; xfer_start = 1; step(); xfer_start = 0;
   endtask

   task automatic end_xfer();
      xfer_end = 1; step(); xfer_end = 0;
   endtask

   task automatic t_reset();
      chk("R10 enables after reset", irq_en, 16'h0);
      chk("R9 status after reset", irq_raw, 16'h0);
      chk("R10 irq after reset", irq, 1'b0);
      chk("R7 rx_level after reset", rx_level, 7'd0);
      chk("R7 tx_left after reset", tx_left, 16'd0);
      chk("R2 rx_req after reset", rx_req, 1'b0);
   endtask

   task automatic t_rx_threshold();
      clear_all();
      rx_thr_field = 6'd3;
      for (int i = 0; i < 4; i++) rx_push(8'hA0 + 8'(i));
      chk("R2 rx_req at threshold", rx_req, 1'b1);
      chk("R7 rx_level four", rx_level, 7'd4);
      step();
      chk("R2 rx_req single pulse", rx_req, 1'b0);
      chk("R2 status bit 3", irq_raw[3], 1'b1);
      for (int i = 0; i < 4; i++) rx_pop_chk("R11 rx order", 8'hA0 + 8'(i));
      chk("R7 rx_level drained", rx_level, 7'd0);
      rx_thr_field = 6'd0;
      rx_push(8'h5C);
      chk("R1 field zero gives threshold one", rx_req, 1'b1);
      rx_pop_chk("R11 rx single byte", 8'h5C);
   endtask

   task automatic t_rx_drain();
      clear_all();
      rx_thr_field = 6'd3;
      start_xfer(1'b0, 16'd6);
      for (int i = 0; i < 6; i++) rx_push(8'h10 + 8'(i));
      for (int i = 0; i < 4; i++) rx_pop_chk("R11 rx burst", 8'h10 + 8'(i));
      end_xfer();
      step();
      chk("R4 receive drain set", irq_raw[13], 1'b1);
      chk("R4 residue count", rx_level, 7'd2);
      rx_pop_chk("R11 residue 0", 8'h14);
      rx_pop_chk("R11 residue 1", 8'h15);
      clear_all();
      start_xfer(1'b0, 16'd0);
      end_xfer(); step(); step();
      chk("R4 no drain on empty FIFO", irq_raw[13], 1'b0);
      start_xfer(1'b0, 16'd1);
      rx_push(8'h31);
      end_xfer(); step();
      chk("R4 drain on single byte", irq_raw[13], 1'b1);
      clear_all();
      chk("R9 write one clears drain", irq_raw[13], 1'b0);
      rx_push(8'h32);
      end_xfer(); step(); step();
      chk("R6 drain only once per transfer", irq_raw[13], 1'b0);
      start_xfer(1'b0, 16'd2);
      end_xfer(); step();
      chk("R6 new transfer re-arms drain", irq_raw[13], 1'b1);
      rx_pop_chk("R11 rx 31", 8'h31);
      rx_pop_chk("R11 rx 32", 8'h32);
   endtask

   task automatic t_access_error();
      clear_all();
      host_rx_pop = 1; step(); host_rx_pop = 0;
      chk("R8 pop of empty RX sets error", irq_raw[7], 1'b1);
      chk("R8 empty pop leaves level", rx_level, 7'd0);
      clear_all();
      chk("R9 error cleared", irq_raw[7], 1'b0);
      host_rx_pop = 1; stat_clr = 16'h0080; step(); host_rx_pop = 0; stat_clr = '0;
      chk("R9 set wins over clear", irq_raw[7], 1'b1);
   endtask

   task automatic t_tx_bursts();
      clear_all();
      tx_thr_field = 6'd3;
      start_xfer(1'b1, 16'd10);
      chk("R7 tx_left loaded", tx_left, 16'd10);
      chk("R3 first tx_req", tx_req, 1'b1);
      for (int i = 0; i < 4; i++) tx_write(8'(i));
      chk("R3 second tx_req", tx_req, 1'b1);
      chk("R7 tx_left after burst", tx_left, 16'd6);
      chk("R3 status bit 4", irq_raw[4], 1'b1);
      for (int i = 4; i < 8; i++) tx_write(8'(i));
      chk("R3 no request below threshold", tx_req, 1'b0);
      step();
      chk("R5 transmit drain set", irq_raw[14], 1'b1);
      chk("R5 residue equals length mod threshold", tx_left, 16'(10 % 4));
      tx_write(8'd8); tx_write(8'd9);
      chk("R7 tx_left zero", tx_left, 16'd0);
      clear_all();
      tx_write(8'hEE);
      chk("R8 write past count sets error", irq_raw[7], 1'b1);
      chk("R8 rejected write keeps tx_left", tx_left, 16'd0);
      for (int i = 0; i < 10; i++) begin
         chk("R11 tx order", bus_tx_data, 8'(i));
         bus_tx_pop = 1; step(); bus_tx_pop = 0;
      end
      end_xfer();
   endtask

   task automatic t_tx_short_irq();
      clear_all();
      irq_en_set = 16'h4000; step(); irq_en_set = '0;
      chk("R10 enable set", irq_en, 16'h4000);
      chk("R10 irq low without status", irq, 1'b0);
      start_xfer(1'b1, 16'd2);
      chk("R5 short transfer no tx_req", tx_req, 1'b0);
      step();
      chk("R5 short transfer drain", irq_raw[14], 1'b1);
      chk("R3 no threshold status", irq_raw[4], 1'b0);
      chk("R10 irq with enabled status", irq, 1'b1);
      irq_en_clr = 16'h4000; step(); irq_en_clr = '0;
      chk("R10 irq off after enable clear", irq, 1'b0);
      tx_write(8'h61); tx_write(8'h62);
      for (int i = 0; i < 2; i++) begin
         bus_tx_pop = 1; step(); bus_tx_pop = 0;
      end
      end_xfer();
   endtask

   task automatic t_rx_full();
      rx_thr_field = 6'd63;
      for (int i = 0; i < 65; i++) rx_push(8'(i));
      chk("R11 full RX drops extra push", rx_level, 7'd64);
      chk("R1 field 63 gives threshold 64", irq_raw[3], 1'b1);
      for (int i = 0; i < 64; i++) rx_pop_chk("R11 full FIFO order", 8'(i));
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_rx_threshold();
      t_rx_drain();
      t_access_error();
      t_tx_bursts();
      t_tx_short_irq();
      clear_all();
      t_rx_full();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule